// File: doc/BRIEF.md
# Sub-Triangle Opacity Hit Filter

This block sits between the ray/triangle intersection stage and the shader dispatch path. For every candidate hit it receives the triangle select (one of the two triangles packed in a leaf), the hit barycentrics u and v, a tag, and the 64-byte leaf node. The leaf carries a 2-bit opacity class for each of four sub-triangles of each triangle, plus one software-emulation flag per triangle.

The filter finds the sub-triangle that was struck by midpoint subdivision of the barycentrics and reads that sub-triangle's opacity class. It then issues one of three verdicts:
- drop the hit, so traversal goes on with no shader launch;
- commit the hit as opaque, which tells the shader to skip alpha testing and ends the ray;
- launch the any-hit shader with alpha testing.

Both sides use valid/ready handshakes. Each accepted hit yields exactly one verdict, one cycle later.

Top module: `subtri_hit_filter`

## Requirements
- R1: Barycentrics are unsigned fixed point with 1.0 = 2^(BARY_W-1), and w = 1 - u - v. The sub-triangle index `out_subtri` is 0 when u >= 1/2, otherwise 1 when v >= 1/2, otherwise 2 when w >= 1/2, otherwise 3. The checks are made in that priority order.
- R2: Sub-triangle k of a triangle uses bits [2k+1:2k] of that triangle's 8-bit opacity field. Triangle 0's field occupies leaf bits [OPQ_LSB+7:OPQ_LSB] and triangle 1's field occupies [OPQ_LSB+15:OPQ_LSB+8]. The default OPQ_LSB is 494.
- R3: Opacity code 2'b00 (transparent) gives verdict 2'b00 (drop), with `out_skip_alpha` = 0 and `out_end_ray` = 0.
- R4: Opacity code 2'b01 (opaque) gives verdict 2'b01 (commit), with `out_skip_alpha` = 1 and `out_end_ray` = 1.
- R5: Opacity code 2'b10 (partial) gives verdict 2'b10 (any-hit with alpha test), with both flags at 0.
- R6: The reserved opacity code 2'b11 is handled exactly like 2'b10.
- R7: When the selected triangle's emulation bit is set, the verdict is 2'b10 with both flags at 0, whatever the opacity code. The emulation bit is at leaf bit OPQ_LSB+16 for triangle 0 and OPQ_LSB+17 for triangle 1.
- R8: `in_tri` picks which triangle's opacity field and emulation bit are used. The other triangle's bits have no effect.
- R9: A hit accepted on a clock edge (`in_valid` and `in_ready` both high) shows `out_valid` high after that edge, carrying the hit's `in_tag`. Every accepted hit produces exactly one verdict, and verdicts leave in acceptance order.
- R10: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Hit candidate present |
| in_ready | output | 1 | Filter can take a hit |
| in_tri | input | 1 | Triangle select within the leaf pair |
| in_u | input | BARY_W | Barycentric u |
| in_v | input | BARY_W | Barycentric v |
| in_leaf | input | LEAF_W | Leaf node contents |
| in_tag | input | TAG_W | Hit identifier, passed through |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Dispatch side takes the verdict |
| out_verdict | output | 2 | 00 drop, 01 commit opaque, 10 any-hit |
| out_skip_alpha | output | 1 | Shader may skip alpha testing |
| out_end_ray | output | 1 | Terminate the ray |
| out_subtri | output | 2 | Sub-triangle index that was hit |
| out_tag | output | TAG_W | Tag of the hit this verdict belongs to |

## Verification
The assertions take for granted that u + v never exceeds 1.0. For such inputs w is not negative, and the subdivision rule is only defined there. The stimulus keeps to this by drawing v from the range 0 to 1.0 - u, and it places the directed corner points exactly on the 1/2 thresholds. The assertions also assume that the dispatch side may lower `out_ready` at any time. The bench exercises this by throttling `out_ready` with a repeating pattern during the random phase, so verdicts queue up behind a stalled output.

// File: rtl/sthf_pkg.sv
`timescale 1ns/1ps
package sthf_pkg;
  localparam int SUBTRI_N    = 4;
  localparam int CODE_W      = 2;
  localparam int TRI_FIELD_W = SUBTRI_N * CODE_W;
  localparam int TRI_N       = 2;

  typedef enum logic [1:0] {
    OPQ_CLEAR = 2'b00,
    OPQ_SOLID = 2'b01,
    OPQ_MIXED = 2'b10,
    OPQ_RSVD  = 2'b11
  } opq_code_e;

  typedef enum logic [1:0] {
    VERD_DROP   = 2'b00,
    VERD_COMMIT = 2'b01,
    VERD_ANYHIT = 2'b10
  } verdict_e;

  typedef struct packed {
    verdict_e   verdict;
    logic       skip_alpha;
    logic       end_ray;
    logic [1:0] subtri;
  } verdict_t;

  // Midpoint subdivision: corners take priority u, v, w; centre otherwise.
  function automatic logic [1:0] pick_subtri(input logic [31:0] u,
                                             input logic [31:0] v,
                                             input logic [31:0] one);
    logic [33:0] uu, vv, oo, ww;
    uu = {2'b00, u};
    vv = {2'b00, v};
    oo = {2'b00, one};
    ww = oo - uu - vv;
    if ((uu << 1) >= oo)      return 2'd0;
    else if ((vv << 1) >= oo) return 2'd1;
    else if ((ww << 1) >= oo) return 2'd2;
    else                      return 2'd3;
  endfunction

  function automatic verdict_t judge(input logic [1:0] code,
                                     input logic       emu,
                                     input logic [1:0] idx);
    verdict_t r;
    r.subtri     = idx;
    r.skip_alpha = 1'b0;
    r.end_ray    = 1'b0;
    r.verdict    = VERD_ANYHIT;
    if (!emu) begin
      case (code)
        OPQ_CLEAR: r.verdict = VERD_DROP;
        OPQ_SOLID: begin
          r.verdict    = VERD_COMMIT;
          r.skip_alpha = 1'b1;
          r.end_ray    = 1'b1;
        end
        default:   r.verdict = VERD_ANYHIT;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/sthf_subtri_locate.sv
`timescale 1ns/1ps
module sthf_subtri_locate #(
  parameter int BARY_W = 12
) (
  input  logic [BARY_W-1:0] u,
  input  logic [BARY_W-1:0] v,
  output logic [1:0]        idx
);
  import sthf_pkg::*;
  localparam logic [31:0] ONE = 32'(1) << (BARY_W - 1);

  always_comb begin
    idx = pick_subtri(32'(u), 32'(v), ONE);
  end
endmodule

// File: rtl/sthf_opacity_fetch.sv
`timescale 1ns/1ps
module sthf_opacity_fetch #(
  parameter int LEAF_W  = 512,
  parameter int OPQ_LSB = 494
) (
  input  logic [LEAF_W-1:0] leaf,
  input  logic              tri_sel,
  input  logic [1:0]        idx,
  output logic [1:0]        code,
  output logic              emu
);
  import sthf_pkg::*;
  localparam int EMU_LSB = OPQ_LSB + TRI_N * TRI_FIELD_W;

  logic [TRI_FIELD_W-1:0] fld      [TRI_N];
  logic [TRI_N-1:0]       emu_bits;

  for (genvar t = 0; t < TRI_N; t++) begin : g_tri
    assign fld[t]      = leaf[OPQ_LSB + t*TRI_FIELD_W +: TRI_FIELD_W];
    assign emu_bits[t] = leaf[EMU_LSB + t];
  end

  always_comb begin
    code = fld[tri_sel][{idx, 1'b0} +: CODE_W];
    emu  = emu_bits[tri_sel];
  end
endmodule

// File: rtl/sthf_verdict_stage.sv
`timescale 1ns/1ps
module sthf_verdict_stage #(
  parameter int TAG_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  sthf_pkg::verdict_t  d_verdict,
  input  logic [TAG_W-1:0]    d_tag,
  output logic                can_load,
  output logic                q_valid,
  input  logic                q_ready,
  output sthf_pkg::verdict_t  q_verdict,
  output logic [TAG_W-1:0]    q_tag
);
  import sthf_pkg::*;

  assign can_load = !q_valid || q_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_verdict <= '0;
      q_tag     <= '0;
    end else begin
      if (load)         q_valid <= 1'b1;
      else if (q_ready) q_valid <= 1'b0;
      if (load) begin
        q_verdict <= d_verdict;
        q_tag     <= d_tag;
      end
    end
  end
endmodule

// File: rtl/subtri_hit_filter.sv
`timescale 1ns/1ps
module subtri_hit_filter #(
  parameter int BARY_W  = 12,
  parameter int LEAF_W  = 512,
  parameter int OPQ_LSB = 494,
  parameter int TAG_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_tri,
  input  logic [BARY_W-1:0] in_u,
  input  logic [BARY_W-1:0] in_v,
  input  logic [LEAF_W-1:0] in_leaf,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_verdict,
  output logic              out_skip_alpha,
  output logic              out_end_ray,
  output logic [1:0]        out_subtri,
  output logic [TAG_W-1:0]  out_tag
);
  import sthf_pkg::*;

  logic       hit_fire;
  logic [1:0] loc_idx;
  logic [1:0] sel_code;
  logic       sel_emu;
  verdict_t   cls;
  verdict_t   held;

  sthf_subtri_locate #(.BARY_W(BARY_W)) u_locate (
    .u   (in_u),
    .v   (in_v),
    .idx (loc_idx)
  );

  sthf_opacity_fetch #(.LEAF_W(LEAF_W), .OPQ_LSB(OPQ_LSB)) u_fetch (
    .leaf    (in_leaf),
    .tri_sel (in_tri),
    .idx     (loc_idx),
    .code    (sel_code),
    .emu     (sel_emu)
  );

  always_comb begin
    cls = judge(sel_code, sel_emu, loc_idx);
  end

  assign hit_fire = in_valid && in_ready;

  sthf_verdict_stage #(.TAG_W(TAG_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (hit_fire),
    .d_verdict (cls),
    .d_tag     (in_tag),
    .can_load  (in_ready),
    .q_valid   (out_valid),
    .q_ready   (out_ready),
    .q_verdict (held),
    .q_tag     (out_tag)
  );

  assign out_verdict    = held.verdict;
  assign out_skip_alpha = held.skip_alpha;
  assign out_end_ray    = held.end_ray;
  assign out_subtri     = held.subtri;
endmodule

// File: rtl/sthf_checker.sv
`timescale 1ns/1ps
module sthf_checker #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic [TAG_W-1:0] in_tag,
  input logic             hit_fire,
  input logic [1:0]       loc_idx,
  input logic [1:0]       sel_code,
  input logic             sel_emu,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_verdict,
  input logic             out_skip_alpha,
  input logic             out_end_ray,
  input logic [1:0]       out_subtri,
  input logic [TAG_W-1:0] out_tag
);
  p_subtri_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> out_subtri == $past(loc_idx));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && !sel_emu && sel_code == 2'b00 |=>
      out_verdict == 2'b00 && !out_skip_alpha && !out_end_ray);

  p_solid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && !sel_emu && sel_code == 2'b01 |=>
      out_verdict == 2'b01 && out_skip_alpha && out_end_ray);

  p_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_skip_alpha == out_end_ray) &&
                  (out_end_ray == (out_verdict == 2'b01)));

  // R5 and R6: both upper codes launch the any-hit shader
  p_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && !sel_emu && sel_code[1] |=> out_verdict == 2'b10);

  p_emulate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && sel_emu |=>
      out_verdict == 2'b10 && !out_skip_alpha && !out_end_ray);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> out_valid && out_tag == $past(in_tag));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_verdict) &&
      $stable(out_tag) && $stable(out_subtri));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind subtri_hit_filter sthf_checker #(.TAG_W(TAG_W)) u_sthf_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_ready       (in_ready),
  .in_tag         (in_tag),
  .hit_fire       (hit_fire),
  .loc_idx        (loc_idx),
  .sel_code       (sel_code),
  .sel_emu        (sel_emu),
  .out_valid      (out_valid),
  .out_ready      (out_ready),
  .out_verdict    (out_verdict),
  .out_skip_alpha (out_skip_alpha),
  .out_end_ray    (out_end_ray),
  .out_subtri     (out_subtri),
  .out_tag        (out_tag)
);

// File: tb/test_subtri_hit_filter.sv
`timescale 1ns/1ps
module test_subtri_hit_filter;
  localparam int BW = 12;
  localparam int ONE = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_tri = 1'b0;
  logic [BW-1:0] in_u = '0;
  logic [BW-1:0] in_v = '0;
  logic [511:0]  in_leaf = '0;
  logic [7:0]    in_tag = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_verdict;
  logic          out_skip_alpha;
  logic          out_end_ray;
  logic [1:0]    out_subtri;
  logic [7:0]    out_tag;

  subtri_hit_filter i_subtri_hit_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tri(in_tri), .in_u(in_u), .in_v(in_v), .in_leaf(in_leaf),
    .in_tag(in_tag), .out_valid(out_valid), .out_ready(out_ready),
    .out_verdict(out_verdict), .out_skip_alpha(out_skip_alpha),
    .out_end_ray(out_end_ray), .out_subtri(out_subtri), .out_tag(out_tag)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    string      req;
    logic [1:0] verd;
    logic       skip;
    logic       endr;
    logic [1:0] sub;
    logic [7:0] tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  logic stall_en = 1'b0;
  int   cyc = 0;
  logic [7:0] next_tag = 8'h01;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sub(input int u, input int v);
    real ur, vr;
    ur = real'(u) / real'(ONE);
    vr = real'(v) / real'(ONE);
    if (ur >= 0.5) return 2'd0;
    if (vr >= 0.5) return 2'd1;
    if (1.0 - ur - vr >= 0.5) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [511:0] make_leaf(input logic [7:0] f0, input logic [7:0] f1,
                                             input logic e0, input logic e1);
    logic [511:0] l;
    l = {16{32'h5A3C_96E1}};
    l[511:494] = {e1, e0, f1, f0};
    return l;
  endfunction

  // Output ready pattern changes just after the rising edge.
  always @(posedge clk) begin
    #1;
    cyc++;
    out_ready = stall_en ? ((cyc % 3) != 1) : 1'b1;
  end

  // Scoreboard monitor: a verdict transfers at the next edge when valid and ready.
  logic       held_pending = 1'b0;
  logic [1:0] held_verd;
  logic [7:0] held_tag;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pending) begin
        check("R10", "held valid", 32'(out_valid), 32'd1);
        check("R10", "held verdict", 32'(out_verdict), 32'(held_verd));
        check("R10", "held tag", 32'(out_tag), 32'(held_tag));
      end
      held_pending = out_valid && !out_ready;
      held_verd = out_verdict;
      held_tag = out_tag;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R9", "unexpected verdict tag", 32'(out_tag), 32'hFFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.req, "verdict", 32'(out_verdict), 32'(e.verd));
          check(e.req, "skip_alpha", 32'(out_skip_alpha), 32'(e.skip));
          check(e.req, "end_ray", 32'(out_end_ray), 32'(e.endr));
          check("R1", "subtri", 32'(out_subtri), 32'(e.sub));
          check("R9", "tag order", 32'(out_tag), 32'(e.tag));
        end
      end
    end
  end

  task automatic send(input string req, input logic tsel, input int u, input int v,
                      input logic [7:0] f0, input logic [7:0] f1,
                      input logic e0, input logic e1);
    exp_t e;
    logic [7:0] f;
    logic [1:0] c;
    e.req = req;
    e.sub = exp_sub(u, v);
    e.tag = next_tag;
    f = tsel ? f1 : f0;
    c = f[2*e.sub +: 2];
    e.skip = 1'b0;
    e.endr = 1'b0;
    if ((tsel ? e1 : e0) || c[1]) e.verd = 2'b10;
    else if (c == 2'b01) begin
      e.verd = 2'b01; e.skip = 1'b1; e.endr = 1'b1;
    end else e.verd = 2'b00;
    @(negedge clk);
    in_tri = tsel;
    in_u = BW'(u);
    in_v = BW'(v);
    in_leaf = make_leaf(f0, f1, e0, e1);
    in_tag = next_tag;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q.push_back(e);
    next_tag++;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    check("R11", "in_ready after reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: one-cycle latency with tag
    send("R9", 1'b0, 100, 100, 8'h00, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    check("R9", "valid one cycle after accept", 32'(out_valid), 32'd1);
    check("R9", "tag one cycle after accept", 32'(out_tag), 32'(next_tag - 8'd1));

    // R1: threshold corners (opaque everywhere so the index shows up)
    send("R1", 1'b0, 1024, 0, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 1023, 0, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 1023, 1023, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 1024, 1024, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 0, 1024, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 0, 0, 8'h55, 8'h00, 1'b0, 1'b0);
    send("R1", 1'b0, 2048, 0, 8'h55, 8'h00, 1'b0, 1'b0);

    // R2: one opaque slot at a time, hit on and off it
    for (int k = 0; k < 4; k++) begin
      int uu, vv;
      logic [7:0] f;
      f = 8'h00;
      f[2*k +: 2] = 2'b01;
      uu = (k == 0) ? 1500 : (k == 3) ? 700 : 100;
      vv = (k == 1) ? 1500 : (k == 3) ? 700 : 100;
      send("R2", 1'b0, uu, vv, f, 8'h00, 1'b0, 1'b0);
      send("R2", 1'b1, uu, vv, 8'h00, f, 1'b0, 1'b0);
      send("R2", 1'b0, (k == 0) ? 100 : 1500, 100, f, 8'h00, 1'b0, 1'b0);
    end

    send("R3", 1'b0, 700, 700, 8'h00, 8'hFF, 1'b0, 1'b0);
    send("R4", 1'b0, 100, 1500, 8'h04, 8'h00, 1'b0, 1'b0);
    send("R5", 1'b0, 100, 100, 8'h20, 8'h00, 1'b0, 1'b0);
    send("R6", 1'b0, 700, 700, 8'hC0, 8'h00, 1'b0, 1'b0);
    send("R6", 1'b1, 1500, 100, 8'h00, 8'h03, 1'b0, 1'b0);
    send("R7", 1'b0, 1500, 100, 8'h01, 8'h00, 1'b1, 1'b0);
    send("R7", 1'b1, 700, 700, 8'h00, 8'h00, 1'b0, 1'b1);
    send("R8", 1'b0, 1500, 100, 8'h01, 8'h02, 1'b0, 1'b1);
    send("R8", 1'b1, 1500, 100, 8'h02, 8'h00, 1'b1, 1'b0);

    // Random phase under back-pressure
    stall_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int uu, vv;
      uu = int'($urandom_range(0, ONE));
      vv = int'($urandom_range(0, ONE - uu));
      send("R9", 1'($urandom), uu, vv, 8'($urandom), 8'($urandom),
           ($urandom % 5) == 0, ($urandom % 5) == 0);
    end
    stall_en = 1'b0;
    for (int w = 0; w < 1000 && (q.size() != 0 || out_valid); w++) @(negedge clk);
    check("R9", "verdicts outstanding after drain", 32'(q.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule